// File: doc/BRIEF.md
# Byte-Wide Bus-Controller Register File with Programmed-I/O FIFO

This block is the register front end of a parallel-bus storage controller. A host reaches sixteen byte registers through a narrow bus. One register address is a data FIFO. Writing that address pushes a byte and reading it pops one. A command register captures an opcode and a mode bit. The mode bit chooses between DMA operation and host-driven (programmed-I/O) operation. The block hands the opcode, the 16-bit transfer length and the 3-bit target number to a command sequencer that sits outside it.

The FIFO keeps a read pointer, a write pointer and a byte count. Every successful pop raises the interrupt request, so the host can keep draining bytes one at a time. When the count drains to zero, both pointers return to slot zero. In programmed-I/O mode, a transfer-information command preloads the count from the transfer length and rewinds both pointers. The bytes already held in the FIFO storage can then be read out again from slot zero.

Top module: `scsi_fifo_regs`

## Requirements
- R1: The register index is address bits [5:2]. Address bits [1:0] and all bits above bit 5 have no effect on which register is reached.
- R2: A write to index 2 when the FIFO holds fewer than DEPTH bytes stores the low data byte at the write pointer, advances the write pointer (wrapping at DEPTH) and raises the count by one on the following clock edge.
- R3: While index 2 is addressed for a read, the read data shows the byte at the read pointer. If the count is nonzero, the read advances the read pointer, lowers the count by one and sets the interrupt request on the following edge. A read at index 2 with a zero count returns the byte most recently popped and changes neither the count nor the interrupt request.
- R4: After the pop that brings the count to zero, both pointers are zero. The next pushed byte therefore lands in slot 0.
- R5: A write to index 3 stores the command byte. On the next edge, the mode output becomes bit 7 (1 = DMA, 0 = programmed I/O), the command code output becomes bits [6:0], and a one-cycle command strobe is raised.
- R6: The transfer length output is {index 1, index 0}, with index 0 as the low byte. The target number output is bits [2:0] of the last byte written to index 4.
- R7: Indices 0, 1, 3, 8 and 11 to 15 read back the last byte written to them. Indices 4 to 7, 9 and 10 always read zero, and writes to 9 and 10 are discarded.
- R8: A command write with bit 7 clear and code 0x10 (transfer information) sets the count to the transfer length, limited to DEPTH. It also sets both pointers to zero and sets the interrupt request. With bit 7 set, the same code leaves the FIFO unchanged.
- R9: A push when the count equals DEPTH is discarded and sets a sticky overflow flag. The count never exceeds DEPTH.
- R10: A synchronous active-high reset clears the count, the pointers, the mode latch, the interrupt request, the overflow flag, the command strobe and all stored registers.
- R11: The irqClear input clears the interrupt request. If a set condition (R3, R8) occurs in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWe | input | 1 | Write strobe, takes precedence over busRe |
| busRe | input | 1 | Read strobe; a read at index 2 pops the FIFO |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the addressed register |
| irqClear | input | 1 | Clears the interrupt request |
| irq | output | 1 | Interrupt request |
| dmaMode | output | 1 | 1 = DMA mode, 0 = programmed-I/O mode |
| cmdCode | output | 7 | Command code for the sequencer |
| cmdStrobe | output | 1 | One-cycle pulse after each command write |
| xferLen | output | 16 | Transfer length |
| targetId | output | 3 | Target number |
| fifoCount | output | $clog2(DEPTH+1) | Bytes held in the FIFO |
| overflow | output | 1 | Sticky push-when-full flag |

## Verification
The bench targets the pointer rewind on drain. It pushes three bytes, drains them, pushes one more, and then uses a transfer-information load of length 1 to read slot 0. A design that does not rewind returns the stale first byte instead of the new one. The bench also pushes past full: a design that wraps silently would corrupt the oldest byte or overshoot the count. It reads an empty FIFO, where a faulty design would underflow the count or raise a spurious interrupt. It issues the transfer-information command in both modes, where a faulty design either ignores the mode bit or fails to clamp a length larger than DEPTH. A seeded random mix of pushes, pops and interrupt clears checks every popped byte and the count against a bench model.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  // strobes from control to FIFO datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic load;
  } fifoCtl_t;

  localparam logic [6:0] CMD_XFER_INFO = 7'h10;
  localparam logic [3:0] IDX_FIFO      = 4'd2;
  localparam logic [3:0] IDX_CMD       = 4'd3;
  localparam logic [3:0] IDX_TARGET    = 4'd4;
endpackage

// File: rtl/sfr_fifo_dp.sv
module sfr_fifo_dp
  import sfr_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  fifoCtl_t                   ctl,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [$clog2(DEPTH+1)-1:0] loadCnt,
  output logic [DATA_W-1:0]          headData,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;

  assign headData = mem[rdPtr];
  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);

  always_ff @(posedge clk) begin
    if (ctl.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (ctl.load) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= loadCnt;
    end else if (ctl.push) begin
      wrPtr <= wrPtr + 1'b1;
      count <= count + 1'b1;
    end else if (ctl.pop) begin
      if (count == CNT_W'(1)) begin
        rdPtr <= '0;
        wrPtr <= '0;
      end else begin
        rdPtr <= rdPtr + 1'b1;
      end
      count <= count - 1'b1;
    end
  end

  AST_PUSH_COUNT: assert property (@(posedge clk) disable iff (rst)
    (ctl.push && !ctl.load) |=> count == $past(count) + 1'b1); // R2
  AST_POP_COUNT: assert property (@(posedge clk) disable iff (rst)
    (ctl.pop && !ctl.push && !ctl.load) |=> count == $past(count) - 1'b1); // R3
  AST_PTR_SNAP: assert property (@(posedge clk) disable iff (rst)
    (ctl.pop && !ctl.push && !ctl.load && count == CNT_W'(1)) |=> (rdPtr == '0 && wrPtr == '0)); // R4
  AST_LOAD: assert property (@(posedge clk) disable iff (rst)
    ctl.load |=> (count == $past(loadCnt) && rdPtr == '0)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH)); // R9
endmodule

// File: rtl/sfr_ctrl.sv
module sfr_ctrl
  import sfr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic                       busWe,
  input  logic                       busRe,
  input  logic [7:0]                 busWdata,
  output logic [7:0]                 busRdata,
  input  logic                       irqClear,
  input  logic [7:0]                 headData,
  input  logic                       full,
  input  logic                       empty,
  output fifoCtl_t                   ctl,
  output logic [$clog2(DEPTH+1)-1:0] loadCnt,
  output logic                       irq,
  output logic                       dmaMode,
  output logic [6:0]                 cmdCode,
  output logic                       cmdStrobe,
  output logic [15:0]                xferLen,
  output logic [2:0]                 targetId,
  output logic                       overflow
);
  localparam int CNT_W  = $clog2(DEPTH+1);
  localparam int NREG   = 16;

  logic [3:0] idx;
  logic [7:0] regs [NREG];
  logic [7:0] lastPop;
  logic       cmdWrite, tiPio, fifoWr;

  assign idx      = busAddr[5:2];
  assign fifoWr   = busWe && idx == IDX_FIFO;
  assign cmdWrite = busWe && idx == IDX_CMD;
  assign tiPio    = cmdWrite && !busWdata[7] && busWdata[6:0] == CMD_XFER_INFO;

  assign ctl.push = fifoWr && !full;
  assign ctl.pop  = busRe && !busWe && idx == IDX_FIFO && !empty;
  assign ctl.load = tiPio;

  assign xferLen  = {regs[1], regs[0]};
  assign cmdCode  = regs[IDX_CMD][6:0];
  assign loadCnt  = (xferLen > 16'(DEPTH)) ? CNT_W'(DEPTH) : xferLen[CNT_W-1:0];

  function automatic logic keepsWrite(input logic [3:0] i);
    return i == 4'd0 || i == 4'd1 || i == 4'd3 || i == 4'd8 || i >= 4'd11;
  endfunction

  assign busRdata = (idx == IDX_FIFO) ? (empty ? lastPop : headData) : regs[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      targetId  <= '0;
      dmaMode   <= 1'b0;
      cmdStrobe <= 1'b0;
      irq       <= 1'b0;
      overflow  <= 1'b0;
      lastPop   <= '0;
    end else begin
      cmdStrobe <= cmdWrite;
      if (busWe && keepsWrite(idx)) regs[idx] <= busWdata;
      if (busWe && idx == IDX_TARGET) targetId <= busWdata[2:0];
      if (cmdWrite) dmaMode <= busWdata[7];
      if (ctl.pop) lastPop <= headData;
      if (fifoWr && full) overflow <= 1'b1;
      if (ctl.pop || tiPio) irq <= 1'b1;
      else if (irqClear) irq <= 1'b0;
    end
  end

  AST_POP_IRQ: assert property (@(posedge clk) disable iff (rst)
    ctl.pop |=> irq); // R3
  AST_DMA_LATCH: assert property (@(posedge clk) disable iff (rst)
    cmdWrite |=> (dmaMode == $past(busWdata[7]) && cmdStrobe)); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R9
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (irqClear && !ctl.pop && !tiPio) |=> !irq); // R11
endmodule

// File: rtl/scsi_fifo_regs.sv
module scsi_fifo_regs
  import sfr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic                       busWe,
  input  logic                       busRe,
  input  logic [7:0]                 busWdata,
  output logic [7:0]                 busRdata,
  input  logic                       irqClear,
  output logic                       irq,
  output logic                       dmaMode,
  output logic [6:0]                 cmdCode,
  output logic                       cmdStrobe,
  output logic [15:0]                xferLen,
  output logic [2:0]                 targetId,
  output logic [$clog2(DEPTH+1)-1:0] fifoCount,
  output logic                       overflow
);
  localparam int CNT_W = $clog2(DEPTH+1);

  fifoCtl_t         ctl;
  logic [7:0]       headData;
  logic [CNT_W-1:0] loadCnt;
  logic             full, empty;

  sfr_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .irqClear(irqClear),
    .headData(headData), .full(full), .empty(empty), .ctl(ctl),
    .loadCnt(loadCnt), .irq(irq), .dmaMode(dmaMode), .cmdCode(cmdCode),
    .cmdStrobe(cmdStrobe), .xferLen(xferLen), .targetId(targetId),
    .overflow(overflow)
  );

  sfr_fifo_dp #(.DEPTH(DEPTH), .DATA_W(8)) uDp (
    .clk(clk), .rst(rst), .ctl(ctl), .wrData(busWdata), .loadCnt(loadCnt),
    .headData(headData), .count(fifoCount), .full(full), .empty(empty)
  );
endmodule

// File: tb/tb_scsi_fifo_regs.sv
module tb_scsi_fifo_regs;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] busAddr = '0;
  logic       busWe = 1'b0, busRe = 1'b0, irqClear = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       irq, dmaMode, cmdStrobe, overflow;
  logic [6:0] cmdCode;
  logic [15:0] xferLen;
  logic [2:0] targetId;
  logic [4:0] fifoCount;

  int errors = 0, checks = 0;
  bit done = 0;

  // bench model of the FIFO
  logic [7:0] mdl [DEPTH];
  int mwp = 0, mrp = 0, mcnt = 0;
  logic [7:0] mLast = '0;

  always #2 clk = ~clk;

  scsi_fifo_regs #(.ADDR_W(8), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .irqClear(irqClear), .irq(irq),
    .dmaMode(dmaMode), .cmdCode(cmdCode), .cmdStrobe(cmdStrobe),
    .xferLen(xferLen), .targetId(targetId), .fifoCount(fifoCount),
    .overflow(overflow)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mkAddr(input int idx);
    logic [1:0] lo = 2'($urandom);
    logic [1:0] hi = 2'($urandom);
    return {hi, idx[3:0], lo};   // R1: only bits [5:2] select
  endfunction

  task automatic busWr(input int idx, input logic [7:0] d);
    @(negedge clk);
    busAddr = mkAddr(idx); busWe = 1; busWdata = d;
    @(negedge clk);
    busWe = 0;
  endtask

  task automatic busRd(input int idx, output logic [7:0] d);
    @(negedge clk);
    busAddr = mkAddr(idx); busRe = 1;
    #1 d = busRdata;
    @(negedge clk);
    busRe = 0;
  endtask

  task automatic push(input logic [7:0] d);
    busWr(2, d);
    if (mcnt < DEPTH) begin
      mdl[mwp] = d; mwp = (mwp + 1) % DEPTH; mcnt++;
    end
  endtask

  task automatic popChk(input string req);
    logic [7:0] d, exp;
    exp = (mcnt > 0) ? mdl[mrp] : mLast;
    busRd(2, d);
    check(req, d, exp);
    if (mcnt > 0) begin
      mLast = exp; mcnt--; mrp = (mrp + 1) % DEPTH;
      if (mcnt == 0) begin mrp = 0; mwp = 0; end
    end
  endtask

  task automatic clrIrq();
    @(negedge clk); irqClear = 1;
    @(negedge clk); irqClear = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    check("R10 count", fifoCount, 0);
    check("R10 irq", irq, 0);
    check("R10 dmaMode", dmaMode, 0);
    check("R10 overflow", overflow, 0);
    check("R10 cmdStrobe", cmdStrobe, 0);

    // R7 readback, R6 outputs
    for (int i = 0; i < 16; i++)
      if (i != 2 && i != 3) busWr(i, 8'(8'h30 + i));
    for (int i = 0; i < 16; i++) begin
      if (i == 2 || i == 3) continue;
      busRd(i, d);
      check("R7 readback", d,
            (i <= 1 || i == 8 || i >= 11) ? 8'h30 + i : 0);
    end
    busWr(4, 8'hFD);
    check("R6 targetId", targetId, 5);
    check("R6 xferLen", xferLen, 16'h3130);

    // R5 command latch
    busWr(3, 8'h85);
    check("R5 dmaMode", dmaMode, 1);
    check("R5 cmdCode", cmdCode, 5);
    check("R5 strobe", cmdStrobe, 1);
    @(negedge clk);
    check("R5 strobe pulse", cmdStrobe, 0);
    busRd(3, d);
    check("R7 cmd readback", d, 8'h85);
    busWr(3, 8'h03);
    check("R5 pio mode", dmaMode, 0);

    // R2 R3 push/pop
    push(8'hA1); push(8'hB2); push(8'hC3);
    check("R2 count", fifoCount, 3);
    check("R3 no irq before pop", irq, 0);
    popChk("R3 pop data");
    check("R3 irq", irq, 1);
    check("R3 count", fifoCount, 2);
    clrIrq();
    check("R11 irqClear", irq, 0);
    popChk("R3 pop data"); popChk("R3 pop data");
    clrIrq();
    popChk("R3 empty read last byte");
    check("R3 empty count", fifoCount, 0);
    check("R3 empty no irq", irq, 0);

    // R4 snap: 3 in, 3 out, one in, reload length 1 -> slot 0 holds the new byte
    push(8'h11); push(8'h22); push(8'h33);
    popChk("R4"); popChk("R4"); popChk("R4");
    push(8'h5E);
    busWr(0, 8'd1); busWr(1, 8'd0);
    busWr(3, 8'h10);
    mcnt = 1; mrp = 0; mwp = 0;
    check("R8 load count", fifoCount, 1);
    popChk("R4 new byte in slot 0");

    // R9 overflow
    for (int i = 0; i < DEPTH + 1; i++) push(8'(8'h40 + i));
    check("R9 count capped", fifoCount, DEPTH);
    check("R9 overflow", overflow, 1);
    popChk("R9 oldest kept");

    // R8 clamp and DMA-mode no effect
    busWr(0, 8'h2C); busWr(1, 8'h01);
    busWr(3, 8'h90);
    check("R8 dma no load", fifoCount, DEPTH - 1);
    clrIrq();
    busWr(3, 8'h10);
    mcnt = DEPTH; mrp = 0; mwp = 0;
    check("R8 clamp", fifoCount, DEPTH);
    check("R8 irq", irq, 1);
    for (int i = 0; i < DEPTH; i++) popChk("R8 replay");
    check("R9 overflow sticky", overflow, 1);

    // random mix with fixed seed
    void'($urandom(32'd1234));
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 9);
      if (op < 5) push(8'($urandom));
      else if (op < 9) popChk("R3 random pop");
      else clrIrq();
      check("R2 random count", fifoCount, mcnt);
    end

    // R10 reset after activity
    push(8'h77);
    busWr(3, 8'h81);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R10 count", fifoCount, 0);
    check("R10 dma", dmaMode, 0);
    check("R10 irq", irq, 0);
    check("R10 overflow", overflow, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule